// File: doc/BRIEF.md
# Clock Synthesizer Divider Configuration Loader

This block keeps the programming state of a frequency synthesizer: a 9-bit feedback divider value, a 3-bit output divider code and a 2-bit test selector. The state can be written in two ways. In the first, the divider values are taken from dedicated pins and frozen by a parallel strobe. In the second, a 14-bit shift register is clocked by a serial clock and copied into the divider registers by a load strobe.

All control and data pins are asynchronous. They are brought into one system clock domain through a synchronizer chain, and their edges are found in logic. The block also drives a registered test pin. Its source is picked by the test selector. The block also raises a flag when the feedback value lies outside the range in which the loop can lock.

Top module: `cfg_loader`

## Requirements
- R1: While `rst_n` is low, `m_val` is 200, `n_val` is 0, `t_val` is 0 and `test_out` is 0.
- R2: While `pload` is low, `m_val` and `n_val` follow `m_pin` and `n_pin`.
- R3: A rising `pload` freezes the divider values taken from the pins. Later pin changes have no effect while `pload` stays high and no serial event occurs.
- R4: While `pload` is high, each rising `sclk` shifts `sdata` into the low end of the 14-bit shift register. A rising `sload` then copies the register into the outputs: bits 13:12 go to `t_val`, bits 11:9 to `n_val` and bits 8:0 to `m_val`. The first bit shifted in therefore ends up in the top bit of `t_val`.
- R5: After `sload` falls, further shifting leaves `m_val`, `n_val` and `t_val` unchanged.
- R6: While `pload` and `sload` are both high, each rising `sclk` shifts the register and also copies the updated register into the outputs.
- R7: A serial transfer replaces values frozen from the pins. A later low `pload` makes the outputs follow the pins again.
- R8: While `pload` is low, `sclk` and `sload` are ignored: the shift register and `t_val` keep their contents.
- R9: In serial mode `test_out` shows the following source for each `t_val` value: 0 for `t_val`=0, `sdata` for `t_val`=1, `mdiv_clk` for `t_val`=2, and `synth_clk` for `t_val`=3.
- R10: `test_out` is 0 while `pload` is low.
- R11: `mr` high forces `test_out` to 0 and leaves `m_val`, `n_val` and `t_val` unchanged.
- R12: `m_range_err` is 1 exactly when `m_val` is below 100 or above 350.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| pload | input | 1 | Parallel load strobe; low makes the outputs follow the pins |
| sload | input | 1 | Serial transfer strobe |
| sclk | input | 1 | Serial shift clock |
| sdata | input | 1 | Serial data bit |
| m_pin | input | 9 | Parallel feedback divider value |
| n_pin | input | 3 | Parallel output divider code |
| mr | input | 1 | Master reset of the output path |
| mdiv_clk | input | 1 | Feedback divider output, observable on the test pin |
| synth_clk | input | 1 | Synthesized clock, observable on the test pin |
| m_val | output | 9 | Current feedback divider value |
| n_val | output | 3 | Current output divider code |
| t_val | output | 2 | Current test selector |
| test_out | output | 1 | Test pin |
| m_range_err | output | 1 | Feedback value outside 100..350 |

## Verification
A table of serial words is shifted in and transferred one after another. The words combine all four test codes, several output codes, and feedback values at and next to both range limits (99, 100, 350, 351), plus 0 and 511. A wrong bit order or a wrong range bound shows up as a field mismatch or a wrong flag. Directed sequences then separate the load paths from each other:
- pin values frozen by the parallel strobe and later overridden by a serial transfer;
- serial activity while in parallel mode, which the shift register must not see;
- bit-by-bit updates with the serial strobe held high;
- the test pin for each source, with the master reset and parallel mode each forcing it low.

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int M_W    = 9,
  parameter int N_W    = 3,
  parameter int T_W    = 2,
  parameter int SYNC   = 2,
  parameter int M_LO   = 100,
  parameter int M_HI   = 350,
  parameter int M_INIT = 200,
  parameter int N_INIT = 0,
  parameter int T_INIT = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pload,
  input  logic           sload,
  input  logic           sclk,
  input  logic           sdata,
  input  logic [M_W-1:0] m_pin,
  input  logic [N_W-1:0] n_pin,
  input  logic           mr,
  input  logic           mdiv_clk,
  input  logic           synth_clk,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_val,
  output logic [T_W-1:0] t_val,
  output logic           test_out,
  output logic           m_range_err
);
  localparam int SR_W = T_W + N_W + M_W;
  localparam int CB   = M_W + N_W;
  localparam int IN_W = CB + 7;
  localparam logic [M_W-1:0] LO = M_W'(M_LO);
  localparam logic [M_W-1:0] HI = M_W'(M_HI);

  logic [IN_W-1:0]            raw;
  logic [SYNC-1:0][IN_W-1:0]  sq;
  logic [IN_W-1:0]            s;

  assign raw = {synth_clk, mdiv_clk, mr, sdata, sclk, sload, pload, n_pin, m_pin};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sq <= '0;
    else        sq <= {sq[SYNC-2:0], raw};

  assign s = sq[SYNC-1];

  logic [M_W-1:0] m_s;
  logic [N_W-1:0] n_s;
  logic pl_s, sl_s, sc_s, sd_s, mr_s, md_s, sy_s;

  assign m_s  = s[M_W-1:0];
  assign n_s  = s[CB-1:M_W];
  assign pl_s = s[CB];
  assign sl_s = s[CB+1];
  assign sc_s = s[CB+2];
  assign sd_s = s[CB+3];
  assign mr_s = s[CB+4];
  assign md_s = s[CB+5];
  assign sy_s = s[CB+6];

  logic sc_d, sl_d;
  logic sclk_rise, sload_rise;
  assign sclk_rise  = sc_s & ~sc_d;
  assign sload_rise = sl_s & ~sl_d;

  logic [SR_W-1:0] shreg, sr_next;
  assign sr_next = sclk_rise ? {shreg[SR_W-2:0], sd_s} : shreg;

  logic sel_bit;
  always_comb begin
    case (t_val)
      2'b00:   sel_bit = 1'b0;
      2'b01:   sel_bit = sd_s;
      2'b10:   sel_bit = md_s;
      default: sel_bit = sy_s;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_d     <= 1'b0;
      sl_d     <= 1'b0;
      shreg    <= '0;
      m_val    <= M_W'(M_INIT);
      n_val    <= N_W'(N_INIT);
      t_val    <= T_W'(T_INIT);
      test_out <= 1'b0;
    end else begin
      sc_d     <= sc_s;
      sl_d     <= sl_s;
      test_out <= pl_s & ~mr_s & sel_bit;
      if (!pl_s) begin
        m_val <= m_s;
        n_val <= n_s;
      end else begin
        shreg <= sr_next;
        if (sload_rise || (sl_s && sclk_rise))
          {t_val, n_val, m_val} <= sr_next;
      end
    end
  end

  assign m_range_err = (m_val < LO) || (m_val > HI);
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int M_W  = 9,
  parameter int N_W  = 3,
  parameter int T_W  = 2,
  parameter int SR_W = 14
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pl_s,
  input logic            mr_s,
  input logic            sclk_rise,
  input logic            sload_rise,
  input logic [SR_W-1:0] shreg,
  input logic [M_W-1:0]  m_s,
  input logic [M_W-1:0]  m_val,
  input logic [N_W-1:0]  n_val,
  input logic [T_W-1:0]  t_val,
  input logic            test_out
);
  a_r2_follow_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !pl_s |=> (m_val == $past(m_s)));

  a_r5_hold_without_event: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_s && !sclk_rise && !sload_rise) |=> $stable({t_val, n_val, m_val}));

  a_r8_shreg_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    !pl_s |=> $stable(shreg));

  a_r8_test_sel_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !pl_s |=> $stable(t_val));

  a_r10_test_low_parallel: assert property (@(posedge clk) disable iff (!rst_n)
    !pl_s |=> !test_out);

  a_r11_mr_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    mr_s |=> !test_out);
endmodule

bind cfg_loader cfg_loader_chk #(.M_W(M_W), .N_W(N_W), .T_W(T_W), .SR_W(SR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pl_s(pl_s), .mr_s(mr_s),
  .sclk_rise(sclk_rise), .sload_rise(sload_rise), .shreg(shreg),
  .m_s(m_s), .m_val(m_val), .n_val(n_val), .t_val(t_val), .test_out(test_out)
);

// File: tb/test_cfg_loader.sv
`timescale 1ns/1ps
module test_cfg_loader;
  logic clk = 0, rst_n = 0;
  logic pload = 0, sload = 0, sclk = 0, sdata = 0, mr = 0, mdiv_clk = 0, synth_clk = 0;
  logic [8:0] m_pin = 9'd123;
  logic [2:0] n_pin = 3'd5;
  logic [8:0] m_val;
  logic [2:0] n_val;
  logic [1:0] t_val;
  logic test_out, m_range_err;

  int n_chk = 0, n_bad = 0;
  logic [13:0] sr = '0;

  always #2.5 clk = ~clk;

  cfg_loader i_cfg_loader (
    .clk(clk), .rst_n(rst_n), .pload(pload), .sload(sload), .sclk(sclk), .sdata(sdata),
    .m_pin(m_pin), .n_pin(n_pin), .mr(mr), .mdiv_clk(mdiv_clk), .synth_clk(synth_clk),
    .m_val(m_val), .n_val(n_val), .t_val(t_val), .test_out(test_out), .m_range_err(m_range_err)
  );

  localparam int NV = 8;
  localparam logic [13:0] VEC [NV] = '{
    {2'b00, 3'd1, 9'd100}, {2'b01, 3'd2, 9'd99},  {2'b10, 3'd7, 9'd350}, {2'b11, 3'd0, 9'd351},
    {2'b00, 3'd5, 9'd0},   {2'b10, 3'd3, 9'd511}, {2'b01, 3'd6, 9'd255}, {2'b11, 3'd4, 9'd200}
  };
  localparam logic [NV-1:0] FLAG = 8'b0011_1010;

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    sdata = b;
    wait_clk(4);
    sclk = 1;
    wait_clk(4);
    sclk = 0;
    wait_clk(4);
    if (pload) sr = {sr[12:0], b};
  endtask

  task automatic shift_word(input logic [13:0] w);
    for (int i = 13; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic pulse_sload();
    sload = 1;
    wait_clk(6);
    sload = 0;
    wait_clk(6);
  endtask

  task automatic check_cfg(input string req, input logic [13:0] w);
    check(req, t_val, w[13:12]);
    check(req, n_val, w[11:9]);
    check(req, m_val, w[8:0]);
  endtask

  initial begin
    #500us;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [13:0] w_last;
    logic [13:0] w_hold;
    logic [13:0] w_t1;
    logic [8:0]  m_keep;

    // R1: reset state
    wait_clk(4);
    check("R1 m", m_val, 200);
    check("R1 n", n_val, 0);
    check("R1 t", t_val, 0);
    check("R1 test", test_out, 0);
    rst_n = 1;
    wait_clk(6);

    // R2: transparent pins
    check("R2 m", m_val, 123);
    check("R2 n", n_val, 5);
    m_pin = 9'd321; n_pin = 3'd2;
    wait_clk(6);
    check("R2 m change", m_val, 321);
    check("R2 n change", n_val, 2);
    check("R10 test low parallel", test_out, 0);

    // R3: rising pload freezes
    pload = 1;
    wait_clk(6);
    m_pin = 9'd17; n_pin = 3'd6;
    wait_clk(6);
    check("R3 m frozen", m_val, 321);
    check("R3 n frozen", n_val, 2);

    // R4, R12: table of serial words
    for (int k = 0; k < NV; k++) begin
      shift_word(VEC[k]);
      pulse_sload();
      check_cfg("R4 word", VEC[k]);
      check("R12 range flag", m_range_err, FLAG[k]);
    end
    w_last = VEC[NV-1];

    // R5: after sload falls, shifting has no effect on the outputs
    shift_word({2'b01, 3'd3, 9'd150});
    check_cfg("R5 hold after fall", w_last);
    w_hold = sr;

    // R8: serial activity in parallel mode is ignored
    pload = 0;
    m_pin = 9'd77; n_pin = 3'd1;
    wait_clk(6);
    shift_word({2'b10, 3'd7, 9'd400});
    pulse_sload();
    check("R8 t kept", t_val, w_last[13:12]);
    check("R7 m follows pins", m_val, 77);
    pload = 1;
    wait_clk(6);
    m_pin = 9'd5;
    wait_clk(6);
    check("R3 m frozen again", m_val, 77);
    pulse_sload();
    check_cfg("R8/R7 shreg kept, serial overrides", w_hold);
    pload = 0;
    wait_clk(6);
    check("R7 pins again", m_val, 5);
    pload = 1;
    wait_clk(6);

    // R6: sload held high passes each bit through
    sload = 1;
    wait_clk(6);
    for (int i = 0; i < 5; i++) begin
      shift_bit(i[0]);
      check_cfg("R6 pass-through", sr);
    end
    sload = 0;
    wait_clk(6);

    // R9: test mux
    w_t1 = {2'b01, 3'd0, 9'd200};
    shift_word(w_t1);
    pulse_sload();
    sdata = 1; wait_clk(6);
    check("R9 sdata 1", test_out, 1);
    sdata = 0; wait_clk(6);
    check("R9 sdata 0", test_out, 0);
    sdata = 1; wait_clk(6);
    // R11: mr forces low, config untouched
    m_keep = m_val;
    mr = 1; wait_clk(6);
    check("R11 test low", test_out, 0);
    check("R11 m kept", m_val, m_keep);
    check("R11 t kept", t_val, 1);
    mr = 0; wait_clk(6);
    check("R11 released", test_out, 1);
    // R10: parallel mode forces low
    pload = 0; wait_clk(6);
    check("R10 test low", test_out, 0);
    pload = 1; wait_clk(6);

    shift_word({2'b10, 3'd0, 9'd200});
    pulse_sload();
    mdiv_clk = 1; wait_clk(6);
    check("R9 mdiv 1", test_out, 1);
    mdiv_clk = 0; wait_clk(6);
    check("R9 mdiv 0", test_out, 0);

    shift_word({2'b11, 3'd0, 9'd200});
    pulse_sload();
    synth_clk = 1; wait_clk(6);
    check("R9 synth 1", test_out, 1);
    synth_clk = 0; wait_clk(6);
    check("R9 synth 0", test_out, 0);

    shift_word({2'b00, 3'd0, 9'd200});
    pulse_sload();
    sdata = 1; mdiv_clk = 1; synth_clk = 1; wait_clk(6);
    check("R9 const low", test_out, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule